// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of binary lock tokens that two agents, a left port and a right port, use to share resources without wait states. Each port sees the tokens in a separate address space. A port reaches that space by raising its semaphore enable while its memory select stays low. The token index comes from a short address. A port asks for a token by writing a 0 and gives it up by writing a 1. It then reads back an all-zeros byte if it holds the token, or an all-ones byte if it does not.

Each port has its own request latch for every token. A request from the side that does not hold the token waits in its latch. When the holder releases, the waiting side takes the token in the same update. Everything runs on one clock. Requests for a free token that arrive in the same cycle resolve to the left port. A read value is captured when the read window opens and stays frozen until the window closes, so a polling agent must close and reopen the window to see a change.

Top module: `sema_bank`

## Requirements
- R1: The token addressed by a port is selected by its `*_addr` index (0 to NUM_SEM-1). An access touches only that token's state and no other token.
- R2: A write on a port (`*_sem_en`=1, `*_mem_sel`=0, `*_wr_en`=1) with `*_wbit`=0 sets that port's request for the token. With `*_wbit`=1 it clears that port's request and releases ownership if the port held it.
- R3: An open read window returns 8'h00 when the reading port owns the token. It returns 8'hFF when the token is free or owned by the other port.
- R4: A request written by the non-owning port does not change ownership. When the owner releases the token, the waiting port becomes owner in that same update.
- R5: When a token is free and both ports request it in the same cycle, the left port becomes owner. A request arriving while the other port already owns the token does not take it over.
- R6: A read window opens in the cycle `*_sem_en`=1, `*_rd_en`=1 and `*_mem_sel`=0 first hold together. The value is captured from the ownership state before that clock edge. `*_rdata` keeps it unchanged while the window stays open, and `*_rdata` is 8'hFF whenever the window was closed at the previous edge.
- R7: An access with `*_mem_sel`=1 is ignored in semaphore space. It changes no request or ownership, and it opens no read window.
- R8: `owner_l` and `owner_r` never have the same bit set. A waiting port that writes 1 before the hand-off withdraws its request, so a later release leaves the token free.
- R9: After reset, every token is free with no request pending, both owner vectors are 0, and both read outputs are 8'hFF.
- R10: `owner_l`/`owner_r` (bit i = token i) change only on the clock edge that registers a write, and they show the new state in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_en | input | 1 | Left semaphore-space enable |
| l_mem_sel | input | 1 | Left memory-array select; blocks semaphore access when high |
| l_wr_en | input | 1 | Left write strobe |
| l_rd_en | input | 1 | Left read (output) enable |
| l_addr | input | IDX_W | Left token index |
| l_wbit | input | 1 | Left write data bit (0 request, 1 release) |
| l_rdata | output | DATA_W | Left read data, 00 = owned by left |
| r_sem_en | input | 1 | Right semaphore-space enable |
| r_mem_sel | input | 1 | Right memory-array select; blocks semaphore access when high |
| r_wr_en | input | 1 | Right write strobe |
| r_rd_en | input | 1 | Right read (output) enable |
| r_addr | input | IDX_W | Right token index |
| r_wbit | input | 1 | Right write data bit (0 request, 1 release) |
| r_rdata | output | DATA_W | Right read data, 00 = owned by right |
| owner_l | output | NUM_SEM | Per-token left ownership |
| owner_r | output | NUM_SEM | Per-token right ownership |

## Verification
The hardest case to reach is a hand-off that happens while the receiving port holds its read window open. The bench first parks a right-side request on a token the left holds, then opens the right read window. With the window still open, it makes the left release. It then checks that ownership has moved while `r_rdata` still shows the frozen all-ones value, and that only a reopened window shows 8'h00. Same-cycle requests are driven on one falling edge from both ports, which exercises the left-wins tie.

// File: rtl/sema_bank_pkg.sv
`timescale 1ns/1ps
package sema_bank_pkg;

    // State of one token: request latches and owner bits per side
    typedef struct packed {
        logic req_l;
        logic req_r;
        logic own_l;
        logic own_r;
    } tok_state_t;

    // State of one read port: window open and captured flag (1 = not owner)
    typedef struct packed {
        logic open;
        logic flag;
    } rd_state_t;

    // Ownership decision; returns {own_l, own_r}. A holder keeps the token
    // while its request stands; otherwise a standing request takes it, left first.
    function automatic logic [1:0] pick_owner(input logic held_l, input logic held_r,
                                              input logic want_l, input logic want_r);
        logic keep_l;
        logic keep_r;
        logic [1:0] res;
        keep_l = held_l & want_l;
        keep_r = held_r & want_r;
        if (keep_l)
            res = 2'b10;
        else if (keep_r)
            res = 2'b01;
        else if (want_l)
            res = 2'b10;
        else if (want_r)
            res = 2'b01;
        else
            res = 2'b00;
        return res;
    endfunction

endpackage

// File: rtl/sema_token.sv
`timescale 1ns/1ps
module sema_token
    import sema_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_bit,
    input  logic r_wr,
    input  logic r_bit,
    output logic own_l,
    output logic own_r
);

    tok_state_t state_d;
    tok_state_t state_q;

    always_comb begin
        logic [1:0] win;
        state_d = state_q;
        if (l_wr)
            state_d.req_l = ~l_bit;
        if (r_wr)
            state_d.req_r = ~r_bit;
        win = pick_owner(state_q.own_l, state_q.own_r, state_d.req_l, state_d.req_r);
        state_d.own_l = win[1];
        state_d.own_r = win[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign own_l = state_q.own_l;
    assign own_r = state_q.own_r;

endmodule

// File: rtl/sema_rdport.sv
`timescale 1ns/1ps
module sema_rdport
    import sema_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              window,
    input  logic              not_owner,
    output logic [DATA_W-1:0] rdata
);

    rd_state_t rd_d;
    rd_state_t rd_q;

    always_comb begin
        rd_d      = rd_q;
        rd_d.open = window;
        if (window && !rd_q.open)
            rd_d.flag = not_owner;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '{open: 1'b0, flag: 1'b1};
        else
            rd_q <= rd_d;
    end

    assign rdata = rd_q.open ? {DATA_W{rd_q.flag}} : {DATA_W{1'b1}};

endmodule

// File: rtl/sema_bank.sv
`timescale 1ns/1ps
module sema_bank
    import sema_bank_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               l_sem_en,
    input  logic               l_mem_sel,
    input  logic               l_wr_en,
    input  logic               l_rd_en,
    input  logic [IDX_W-1:0]   l_addr,
    input  logic               l_wbit,
    output logic [DATA_W-1:0]  l_rdata,
    input  logic               r_sem_en,
    input  logic               r_mem_sel,
    input  logic               r_wr_en,
    input  logic               r_rd_en,
    input  logic [IDX_W-1:0]   r_addr,
    input  logic               r_wbit,
    output logic [DATA_W-1:0]  r_rdata,
    output logic [NUM_SEM-1:0] owner_l,
    output logic [NUM_SEM-1:0] owner_r
);

    logic l_legal;
    logic r_legal;
    logic l_wr;
    logic r_wr;
    logic l_win;
    logic r_win;

    // Semaphore space is reachable only with the memory select low
    assign l_legal = l_sem_en & ~l_mem_sel;
    assign r_legal = r_sem_en & ~r_mem_sel;
    assign l_wr    = l_legal & l_wr_en;
    assign r_wr    = r_legal & r_wr_en;
    assign l_win   = l_legal & l_rd_en;
    assign r_win   = r_legal & r_rd_en;

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_tok
        logic hit_l;
        logic hit_r;
        assign hit_l = l_wr && (l_addr == IDX_W'(i));
        assign hit_r = r_wr && (r_addr == IDX_W'(i));

        sema_token u_tok (
            .clk   (clk),
            .rst_n (rst_n),
            .l_wr  (hit_l),
            .l_bit (l_wbit),
            .r_wr  (hit_r),
            .r_bit (r_wbit),
            .own_l (owner_l[i]),
            .own_r (owner_r[i])
        );
    end

    sema_rdport #(.DATA_W(DATA_W)) u_rd_l (
        .clk       (clk),
        .rst_n     (rst_n),
        .window    (l_win),
        .not_owner (~owner_l[l_addr]),
        .rdata     (l_rdata)
    );

    sema_rdport #(.DATA_W(DATA_W)) u_rd_r (
        .clk       (clk),
        .rst_n     (rst_n),
        .window    (r_win),
        .not_owner (~owner_r[r_addr]),
        .rdata     (r_rdata)
    );

endmodule

// File: rtl/sema_bank_chk.sv
`timescale 1ns/1ps
module sema_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sem_en,
    input logic               l_mem_sel,
    input logic               l_wr_en,
    input logic               l_rd_en,
    input logic [IDX_W-1:0]   l_addr,
    input logic               l_wbit,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sem_en,
    input logic               r_mem_sel,
    input logic               r_wr_en,
    input logic               r_rd_en,
    input logic [IDX_W-1:0]   r_addr,
    input logic               r_wbit,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] owner_l,
    input logic [NUM_SEM-1:0] owner_r
);

    logic wl;
    logic wr;
    logic vl;
    logic vr;
    assign wl = l_sem_en & ~l_mem_sel & l_wr_en;
    assign wr = r_sem_en & ~r_mem_sel & r_wr_en;
    assign vl = l_sem_en & ~l_mem_sel & l_rd_en;
    assign vr = r_sem_en & ~r_mem_sel & r_rd_en;

    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_l & owner_r) == '0);

    // Covers R10 and R7: without a legal write the owners hold
    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wl || wr) |=> ($stable(owner_l) && $stable(owner_r)));

    assert_frozen_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vl && $past(vl)) |=> $stable(l_rdata));

    assert_frozen_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vr && $past(vr)) |=> $stable(r_rdata));

    assert_idle_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vl |=> (l_rdata == '1));

    assert_idle_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vr |=> (r_rdata == '1));

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
        assert_left_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!owner_l[i] && !owner_r[i] && wl && l_addr == IDX_W'(i) && !l_wbit)
            |=> owner_l[i]);

        assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_l[i] && wl && l_addr == IDX_W'(i) && l_wbit) |=> !owner_l[i]);

        assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_r[i] && wr && r_addr == IDX_W'(i) && r_wbit && !(wl && l_addr == IDX_W'(i)))
            |=> !owner_r[i]);
    end

endmodule

bind sema_bank sema_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/sema_bank_tb_top.sv
`timescale 1ns/1ps
module sema_bank_tb_top;

    localparam int NUM_SEM = 8;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 3;

    typedef struct packed {
        logic [1:0]  op;     // 0 left write, 1 right write, 2 both write
        logic [2:0]  idx;
        logic        wbit;
        logic [7:0]  exp_l;
        logic [7:0]  exp_r;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd3, 1'b0, 8'h08, 8'h00},  // R2 left takes 3
        '{2'd1, 3'd3, 1'b0, 8'h08, 8'h00},  // R4 right waits
        '{2'd0, 3'd3, 1'b1, 8'h00, 8'h08},  // R4 hand-off to right
        '{2'd0, 3'd3, 1'b0, 8'h00, 8'h08},  // R4 left waits
        '{2'd1, 3'd3, 1'b1, 8'h08, 8'h00},  // R4 hand-off to left
        '{2'd0, 3'd3, 1'b1, 8'h00, 8'h00},  // R2 free
        '{2'd1, 3'd3, 1'b0, 8'h00, 8'h08},  // R2 right takes 3
        '{2'd1, 3'd3, 1'b1, 8'h00, 8'h00},  // R2 free
        '{2'd2, 3'd5, 1'b0, 8'h20, 8'h00},  // R5 tie to left
        '{2'd0, 3'd5, 1'b1, 8'h00, 8'h20},  // R4 right pending from tie
        '{2'd1, 3'd5, 1'b1, 8'h00, 8'h00},  // R2 free
        '{2'd1, 3'd0, 1'b0, 8'h00, 8'h01},  // R1 token 0 only
        '{2'd0, 3'd0, 1'b0, 8'h00, 8'h01},  // R5 later request no takeover
        '{2'd0, 3'd0, 1'b1, 8'h00, 8'h01},  // R8 withdraw
        '{2'd1, 3'd0, 1'b1, 8'h00, 8'h00}   // R8 free after withdraw
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sem_en = 0, l_mem_sel = 0, l_wr_en = 0, l_rd_en = 0, l_wbit = 0;
    logic r_sem_en = 0, r_mem_sel = 0, r_wr_en = 0, r_rd_en = 0, r_wbit = 0;
    logic [IDX_W-1:0] l_addr = '0;
    logic [IDX_W-1:0] r_addr = '0;
    logic [DATA_W-1:0] l_rdata;
    logic [DATA_W-1:0] r_rdata;
    logic [NUM_SEM-1:0] owner_l;
    logic [NUM_SEM-1:0] owner_r;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sema_bank #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) dut_i (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_sem_en = 0; l_wr_en = 0; l_rd_en = 0; l_mem_sel = 0;
        r_sem_en = 0; r_wr_en = 0; r_rd_en = 0; r_mem_sel = 0;
    endtask

    // Drive a write at a falling edge; owners checked at the next falling edge
    task automatic do_write(input bit lw, input bit rw, input logic [2:0] la,
                            input logic [2:0] ra, input logic lb, input logic rb);
        @(negedge clk);
        if (lw) begin l_sem_en = 1; l_wr_en = 1; l_addr = la; l_wbit = lb; end
        if (rw) begin r_sem_en = 1; r_wr_en = 1; r_addr = ra; r_wbit = rb; end
        @(negedge clk);
        idle();
    endtask

    task automatic do_read(input bit right, input logic [2:0] a, output logic [7:0] val);
        @(negedge clk);
        if (right) begin r_sem_en = 1; r_rd_en = 1; r_addr = a; end
        else       begin l_sem_en = 1; l_rd_en = 1; l_addr = a; end
        @(negedge clk);
        val = right ? r_rdata : l_rdata;
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check("R9 owner_l", owner_l, 8'h00);
        check("R9 owner_r", owner_r, 8'h00);
        check("R9 l_rdata", l_rdata, 8'hFF);
        check("R9 r_rdata", r_rdata, 8'hFF);

        // Vector walk: R1 R2 R4 R5 R8 R10
        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k].op != 2'd1, VEC[k].op != 2'd0, VEC[k].idx, VEC[k].idx,
                     VEC[k].wbit, VEC[k].wbit);
            check($sformatf("R10 vec%0d owner_l", k), owner_l, VEC[k].exp_l);
            check($sformatf("R10 vec%0d owner_r", k), owner_r, VEC[k].exp_r);
        end

        // R3 read values
        do_write(1, 0, 3'd2, 3'd0, 1'b0, 1'b0);
        do_read(0, 3'd2, v); check("R3 owner reads 00", v, 8'h00);
        do_read(1, 3'd2, v); check("R3 other reads FF", v, 8'hFF);
        do_read(0, 3'd4, v); check("R3 free reads FF", v, 8'hFF);

        // R6 frozen read across a hand-off
        do_write(0, 1, 3'd0, 3'd2, 1'b0, 1'b0);
        @(negedge clk);
        r_sem_en = 1; r_rd_en = 1; r_addr = 3'd2;
        @(negedge clk);
        check("R6 first capture", r_rdata, 8'hFF);
        l_sem_en = 1; l_wr_en = 1; l_addr = 3'd2; l_wbit = 1'b1;
        @(negedge clk);
        l_sem_en = 0; l_wr_en = 0;
        check("R4 hand-off under read", owner_r, 8'h04);
        @(negedge clk);
        check("R6 held while open", r_rdata, 8'hFF);
        idle();
        @(negedge clk);
        check("R6 idle FF", r_rdata, 8'hFF);
        do_read(1, 3'd2, v); check("R6 reopen sees 00", v, 8'h00);

        // R7 memory select blocks semaphore access
        @(negedge clk);
        l_sem_en = 1; l_mem_sel = 1; l_wr_en = 1; l_addr = 3'd6; l_wbit = 1'b0;
        @(negedge clk);
        idle();
        check("R7 write ignored l", owner_l, 8'h00);
        check("R7 write ignored r", owner_r, 8'h04);
        @(negedge clk);
        r_sem_en = 1; r_mem_sel = 1; r_rd_en = 1; r_addr = 3'd2;
        @(negedge clk);
        check("R7 no read window", r_rdata, 8'hFF);
        idle();

        // R2 release
        do_write(0, 1, 3'd0, 3'd2, 1'b0, 1'b1);
        check("R2 final release", owner_r, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule